// File: doc/BRIEF.md
# Double-Buffered DAC Input Register

This block is the digital front end of a parallel-input digital-to-analog converter. A 16-bit data word reaches the converter core through two register stages. The first is an input register, loaded while an active-low capture strobe is asserted. The second is a DAC register, loaded from the input register while an active-high update strobe is asserted. The DAC register drives the output code seen by the converter core. Because every instance on a shared bus can be captured separately and then updated by one common update strobe, several converters can change their outputs together.

Both strobes, and the data word with them, pass through a two-flop synchronizer into the system clock domain. Each level-sensitive stage is then modelled as a register that reloads on every clock cycle while its enable level is active. An asynchronous active-low reset forces both stages to a reset code without waiting for a clock. A static select pin picks that code: all zeros, or midscale with only the top bit set.

Top module: `dac_dbuf_front`

## Requirements
- R1: While `arst_n` is low and `mid_sel` is 0, `code_o` is 0x0000 at once, with no clock edge needed, whatever the strobes and data do.
- R2: While `arst_n` is low and `mid_sel` is 1, `code_o` is 0x8000 (bit 15 set, all other bits clear) at once, whatever the strobes and data do.
- R3: Reset presets the input register to the same code as the DAC register, so an update strobe that follows with no capture keeps the reset code on `code_o`.
- R4: With `cap_n` = 0 and `upd` = 0, the input register takes `din` on every cycle and `code_o` does not change.
- R5: With `cap_n` = 1 and `upd` = 1, the DAC register takes the input register contents, and `code_o` shows them.
- R6: With `cap_n` = 0 and `upd` = 1, both stages are transparent, so `din` reaches `code_o` and also stays in the input register.
- R7: With `cap_n` = 1 and `upd` = 0, neither register changes: `code_o` holds, and a later update shows the input register as it was.
- R8: When `cap_n` and `upd` are tied to one pulse, the word on `din` while the pulse is low is captured. On the rising edge it moves to `code_o`, even if `din` changes on that same edge.
- R9: Bit i of `din` maps to bit i of `code_o` for every i from 0 (LSB) to 15 (MSB).
- R10: A change on the pins appears on `code_o` on the third rising clock edge after it, never earlier. Data and strobes are sampled in the same cycle, and `code_o` follows R3 to R8 on every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| arst_n | input | 1 | Asynchronous reset, active low |
| mid_sel | input | 1 | Reset code select: 0 gives zero, 1 gives midscale; static |
| cap_n | input | 1 | Input register strobe, active low |
| upd | input | 1 | DAC register strobe, active high |
| din | input | 16 | Parallel data word, bit 15 the MSB |
| code_o | output | 16 | Output code to the converter core |

## Verification
The capture and the update of the DAC register can occur in the same cycle. This happens when both strobes are active (the transparent case), and again at the rising edge of a tied pulse, where fresh data and the strobe change together. The bench provokes both cases directly. It also runs long pseudo-random strobe and data sequences, and compares `code_o` on every cycle with an arithmetic model of the two stages behind a three-edge latency. Reset is asserted in the middle of activity with each select value, and the reset code is judged before any clock edge follows.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;

    // bit 0: input stage loads, bit 1: DAC stage loads
    typedef enum logic [1:0] {
        OP_HOLD    = 2'b00,
        OP_CAPTURE = 2'b01,
        OP_LOAD    = 2'b10,
        OP_THRU    = 2'b11
    } op_e;

endpackage

// File: rtl/dacfe_sync.sv
module dacfe_sync #(
    parameter int          W       = 1,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         arst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] stg_d [STAGES];
    logic [W-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = d_i;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stg_q[i] <= RST_VAL;
            end
        end else begin
            for (int i = 0; i < STAGES; i++) begin
                stg_q[i] <= stg_d[i];
            end
        end
    end

    assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/dacfe_decode.sv
module dacfe_decode
    import dacfe_pkg::*;
(
    input  logic cap_n_i,
    input  logic upd_i,
    output op_e  op_o
);

    always_comb begin
        unique case ({upd_i, cap_n_i})
            2'b00:   op_o = OP_CAPTURE;
            2'b01:   op_o = OP_HOLD;
            2'b10:   op_o = OP_THRU;
            default: op_o = OP_LOAD;
        endcase
    end

endmodule

// File: rtl/dacfe_stage.sv
module dacfe_stage #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         arst_n,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    input  logic         at_rst_i,
    output logic [W-1:0] val_o,
    output logic         at_rst_o
);

    typedef struct packed {
        logic [W-1:0] val;
        logic         at_rst;
    } stage_t;

    stage_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.val    = val_i;
            st_d.at_rst = at_rst_i;
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            st_q <= '{val: '0, at_rst: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign val_o    = st_q.val;
    assign at_rst_o = st_q.at_rst;

    // R7: an idle stage keeps both value and reset marker
    a_r7_stage_idle: assert property (@(posedge clk) disable iff (!arst_n)
        !load_i |=> ($stable(val_o) && $stable(at_rst_o)));

    // R4: a loading stage shows the offered word one edge later
    a_r4_stage_take: assert property (@(posedge clk) disable iff (!arst_n)
        load_i |=> (val_o == $past(val_i) && at_rst_o == $past(at_rst_i)));

endmodule

// File: rtl/dac_dbuf_front.sv
module dac_dbuf_front
    import dacfe_pkg::*;
#(
    parameter int W      = 16,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         arst_n,
    input  logic         mid_sel,
    input  logic         cap_n,
    input  logic         upd,
    input  logic [W-1:0] din,
    output logic [W-1:0] code_o
);

    localparam logic [W-1:0] MID_CODE  = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] ZERO_CODE = '0;

    // strobe pair idles as capture inactive, update inactive
    logic [1:0]   strb_s;
    logic [W-1:0] dat_s;
    op_e          op;

    logic [W-1:0] in_val, dac_val, dac_src_val;
    logic         in_rst, dac_rst, dac_src_rst;
    logic [W-1:0] rst_code, in_code;

    dacfe_sync #(.W(2), .STAGES(STAGES), .RST_VAL(2'b01)) u_strb_sync (
        .clk    (clk),
        .arst_n (arst_n),
        .d_i    ({upd, cap_n}),
        .q_o    (strb_s)
    );

    dacfe_sync #(.W(W), .STAGES(STAGES), .RST_VAL('0)) u_data_sync (
        .clk    (clk),
        .arst_n (arst_n),
        .d_i    (din),
        .q_o    (dat_s)
    );

    dacfe_decode u_decode (
        .cap_n_i (strb_s[0]),
        .upd_i   (strb_s[1]),
        .op_o    (op)
    );

    dacfe_stage #(.W(W)) u_in_stage (
        .clk      (clk),
        .arst_n   (arst_n),
        .load_i   (op[0]),
        .val_i    (dat_s),
        .at_rst_i (1'b0),
        .val_o    (in_val),
        .at_rst_o (in_rst)
    );

    // transparent case forwards the word the input stage is taking now
    always_comb begin
        if (op == OP_THRU) begin
            dac_src_val = dat_s;
            dac_src_rst = 1'b0;
        end else begin
            dac_src_val = in_val;
            dac_src_rst = in_rst;
        end
    end

    dacfe_stage #(.W(W)) u_dac_stage (
        .clk      (clk),
        .arst_n   (arst_n),
        .load_i   (op[1]),
        .val_i    (dac_src_val),
        .at_rst_i (dac_src_rst),
        .val_o    (dac_val),
        .at_rst_o (dac_rst)
    );

    assign rst_code = mid_sel ? MID_CODE : ZERO_CODE;
    assign in_code  = in_rst  ? rst_code : in_val;
    assign code_o   = dac_rst ? rst_code : dac_val;

    // R1 / R2: reset code shown while reset is held
    always @(negedge clk) begin
        if (!arst_n) begin
            a_r1_reset_code: assert (code_o == (mid_sel ? MID_CODE : ZERO_CODE));
        end
    end

    // R4: capture leaves the output alone and fills the input register
    a_r4_capture: assert property (@(posedge clk) disable iff (!arst_n)
        (op == OP_CAPTURE) |=> ($stable(code_o) && in_code == $past(dat_s)));

    // R5: update copies the input register to the output
    a_r5_update: assert property (@(posedge clk) disable iff (!arst_n)
        (op == OP_LOAD) |=> (code_o == $past(in_code)));

    // R6: both stages transparent
    a_r6_thru: assert property (@(posedge clk) disable iff (!arst_n)
        (op == OP_THRU) |=> (code_o == $past(dat_s) && in_code == $past(dat_s)));

    // R7: no strobe active, nothing moves
    a_r7_hold: assert property (@(posedge clk) disable iff (!arst_n)
        (op == OP_HOLD) |=> ($stable(code_o) && $stable(in_code)));

endmodule

// File: tb/sim_dac_dbuf_front.sv
module sim_dac_dbuf_front;

    logic        clk = 1'b0;
    logic        arst_n = 1'b0;
    logic        mid_sel = 1'b0;
    logic        cap_n = 1'b0;
    logic        upd = 1'b1;
    logic [15:0] din = 16'hFFFF;
    logic [15:0] code_o;

    int tests = 0;
    int fails = 0;
    logic mon_en = 1'b0;
    logic done = 1'b0;

    always #2 clk = ~clk;

    dac_dbuf_front u0 (
        .clk     (clk),
        .arst_n  (arst_n),
        .mid_sel (mid_sel),
        .cap_n   (cap_n),
        .upd     (upd),
        .din     (din),
        .code_o  (code_o)
    );

    task automatic chk(input string tag, input logic [15:0] exp);
        tests++;
        if (code_o !== exp) begin
            fails++;
            $display("FAIL %s: code_o=%h expected %h at %0t", tag, code_o, exp, $time);
        end
    endtask

    // reference: two sync edges, then one register edge
    logic [17:0] m_s1, m_s2;   // {upd, cap_n, data}
    logic [15:0] m_in, m_dac;

    always @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            m_s1  <= {2'b01, 16'h0000};
            m_s2  <= {2'b01, 16'h0000};
            m_in  <= mid_sel ? 16'h8000 : 16'h0000;
            m_dac <= mid_sel ? 16'h8000 : 16'h0000;
        end else begin
            m_s1 <= {upd, cap_n, din};
            m_s2 <= m_s1;
            if (!m_s2[16]) m_in <= m_s2[15:0];
            if (m_s2[17]) m_dac <= m_s2[16] ? m_in : m_s2[15:0];
        end
    end

    // R10: every-cycle comparison against the reference
    always @(negedge clk) begin
        if (mon_en) chk("R10", m_dac);
    end

    task automatic drive(input logic c, input logic u, input logic [15:0] d);
        @(negedge clk);
        cap_n = c;
        upd   = u;
        din   = d;
    endtask

    task automatic waitn(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] lf;
        // R1: zero reset code, strobes active during reset
        #1 chk("R1", 16'h0000);
        waitn(3);
        chk("R1", 16'h0000);

        drive(1'b1, 1'b0, 16'hFFFF);
        arst_n = 1'b1;
        mon_en = 1'b1;
        waitn(4);
        chk("R1", 16'h0000);

        // R3: update without capture keeps reset code
        drive(1'b1, 1'b1, 16'hFFFF);
        waitn(4);
        chk("R3", 16'h0000);

        // R4: capture, output unchanged
        drive(1'b0, 1'b0, 16'h1234);
        waitn(4);
        chk("R4", 16'h0000);

        // R5: update shows captured word, bus ignored
        drive(1'b1, 1'b1, 16'hFFFF);
        waitn(4);
        chk("R5", 16'h1234);

        // R7: hold ignores bus; later update still shows 1234
        drive(1'b1, 1'b0, 16'hAAAA);
        waitn(4);
        chk("R7", 16'h1234);
        drive(1'b1, 1'b1, 16'h5555);
        waitn(4);
        chk("R7", 16'h1234);

        // R6 / R9: transparent walking ones
        for (int i = 0; i < 16; i++) begin
            drive(1'b0, 1'b1, 16'(1) << i);
            waitn(3);
            chk("R9", 16'(1) << i);
        end
        drive(1'b0, 1'b1, 16'hA55A);
        waitn(4);
        chk("R6", 16'hA55A);
        // transparent word also kept in the input register
        drive(1'b1, 1'b1, 16'h0F0F);
        waitn(4);
        chk("R6", 16'hA55A);

        // R10: exact three-edge latency
        drive(1'b0, 1'b1, 16'h5A5A);
        waitn(4);
        drive(1'b0, 1'b1, 16'hC3C3);
        waitn(2);
        chk("R10", 16'h5A5A);
        waitn(1);
        chk("R10", 16'hC3C3);

        // R8: tied pulse, data changes on the rising edge
        drive(1'b1, 1'b1, 16'h0000);
        waitn(4);
        drive(1'b0, 1'b0, 16'hBEEF);
        waitn(4);
        chk("R8", 16'hC3C3);
        drive(1'b1, 1'b1, 16'h0000);
        waitn(4);
        chk("R8", 16'hBEEF);

        // R2: midscale reset in the middle of activity
        drive(1'b0, 1'b1, 16'h7777);
        mid_sel = 1'b1;
        @(posedge clk);
        #1 arst_n = 1'b0;
        #0.5 chk("R2", 16'h8000);
        waitn(3);
        chk("R2", 16'h8000);
        drive(1'b1, 1'b1, 16'h1111);
        arst_n = 1'b1;
        waitn(5);
        chk("R3", 16'h8000);

        // pseudo-random sweep with each reset select
        for (int pass = 0; pass < 2; pass++) begin
            lf = (pass == 0) ? 16'hACE1 : 16'h1D2B;
            for (int n = 0; n < 800; n++) begin
                drive(lf[0], lf[7], lf ^ {lf[7:0], lf[15:8]});
                lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            end
            @(posedge clk);
            #1 arst_n = 1'b0;
            mid_sel = (pass == 0) ? 1'b0 : 1'b1;
            waitn(2);
            chk(mid_sel ? "R2" : "R1", mid_sel ? 16'h8000 : 16'h0000);
            drive(1'b1, 1'b0, 16'h0000);
            arst_n = 1'b1;
        end
        waitn(4);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule